// File: doc/BRIEF.md
# Bidirectional Logarithmic Barrel Shifter

This block moves a data word left or right by any count from zero to one less than the word width, in a single combinational pass. Shifting left brings zeros into the low-order positions. Shifting right either brings in zeros (logical mode) or repeats the word's original sign bit (arithmetic mode). It is meant to sit in a datapath next to an adder and a logic unit, and to be selected by an operation mux.

The hardware contains only one shifter, and it shifts left. It is a chain of 2:1 mux stages. Stage k moves the word by 2^k places when bit k of the count is set. For a right shift, a row of per-bit muxes reverses the bit order of the word before the chain. A second row reverses it again after the chain. In arithmetic right mode, the value fed into the positions the chain empties is the original most significant bit instead of zero. The arithmetic control has no effect when the direction is left.

Top module: `bidir_barrel_shifter`

## Requirements
- R1: With `dir_right`=0, `data_out` equals `data_in` shifted toward the MSB by `shift_amt`, with the `shift_amt` low-order bits equal to 0 and bits above the width discarded.
- R2: With `dir_right`=1 and `arith_mode`=0, `data_out` equals `data_in` shifted toward the LSB by `shift_amt`, with the `shift_amt` high-order bits equal to 0.
- R3: With `dir_right`=1 and `arith_mode`=1, `data_out` equals `data_in` shifted toward the LSB by `shift_amt`, with the `shift_amt` high-order bits equal to `data_in[WIDTH-1]`. For example, 8'b11101100 shifted by 1 gives 8'b11110110.
- R4: With `dir_right`=0, the value of `arith_mode` has no effect on `data_out`.
- R5: With `shift_amt`=0, `data_out` equals `data_in` for every setting of `dir_right` and `arith_mode`.
- R6: With `dir_right`=0 and `shift_amt`=WIDTH-1, `data_out` has `data_in[0]` in its MSB and zeros in every other bit.
- R7: With `dir_right`=1 and `shift_amt`=WIDTH-1, `data_out` is all copies of `data_in[WIDTH-1]` in arithmetic mode. In logical mode it is `data_in[WIDTH-1]` in bit 0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be shifted |
| shift_amt | input | $clog2(WIDTH) | Number of bit positions to move, 0 to WIDTH-1 |
| dir_right | input | 1 | 0 = shift toward MSB, 1 = shift toward LSB |
| arith_mode | input | 1 | In a right shift, 1 = sign fill and 0 = zero fill; ignored for left shifts |
| data_out | output | WIDTH | Shifted word |

## Verification
The checker is evaluated whenever an input changes. It tests the vacated bit positions in each mode: zero low bits for left shifts, zero high bits for logical right shifts, and sign-filled high bits for arithmetic right shifts of negative words. It also tests the zero-count pass-through and the full-width left shift. Whether the surviving bits actually arrive in the correct positions, and whether the arithmetic control is really inert for left shifts, are shown by the bench. The bench sweeps every data word, count, direction and mode of the 8-bit configuration against arithmetic reference values.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/bit_reverse.sv
module bit_reverse #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign dout[i] = din[WIDTH-1-i];
  end
endmodule

// File: rtl/shift_stage.sv
// One power-of-two stage of the left-shift cascade.
module shift_stage #(
  parameter int WIDTH = 8,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             en,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    if (en) dout = {din[WIDTH-1-DIST:0], {DIST{fill}}};
    else    dout = din;
  end
endmodule

// File: rtl/bidir_barrel_shifter.sv
module bidir_barrel_shifter
  import barrel_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [SHW-1:0]   shift_amt,
  input  logic             dir_right,
  input  logic             arith_mode,
  output logic [WIDTH-1:0] data_out
);
  logic             go_right;
  logic             fill_bit;
  logic [WIDTH-1:0] in_rev;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] core_rev;
  logic [WIDTH-1:0] stg [0:SHW];

  assign go_right = (shift_dir_e'(dir_right) == DIR_RIGHT);
  // Sign fill applies only to arithmetic right shifts.
  assign fill_bit = go_right & arith_mode & data_in[WIDTH-1];

  bit_reverse #(.WIDTH(WIDTH)) rev_in_i (.din(data_in), .dout(in_rev));

  // Input-side reversal mux.
  assign stg[0] = go_right ? in_rev : data_in;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    shift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) stage_i (
      .din  (stg[k]),
      .en   (shift_amt[k]),
      .fill (fill_bit),
      .dout (stg[k+1])
    );
  end

  assign core_out = stg[SHW];

  bit_reverse #(.WIDTH(WIDTH)) rev_out_i (.din(core_out), .dout(core_rev));

  // Output-side reversal mux.
  assign data_out = go_right ? core_rev : core_out;
endmodule

// File: rtl/bidir_barrel_shifter_chk.sv
module bidir_barrel_shifter_chk #(
  parameter int WIDTH = 8,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_in,
  input logic [SHW-1:0]   shift_amt,
  input logic             dir_right,
  input logic             arith_mode,
  input logic [WIDTH-1:0] data_out
);
  logic [WIDTH-1:0] ones;
  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] high_mask;

  assign ones      = '1;
  assign low_mask  = ~(ones << shift_amt);
  assign high_mask = ~(ones >> shift_amt);

  always_comb begin
    assert_zero_pass_R5: assert (shift_amt != '0 || data_out == data_in)
      else $error("R5 pass-through violated");
    assert_left_low_zero_R1: assert (dir_right || (data_out & low_mask) == '0)
      else $error("R1 low fill not zero");
    assert_logic_high_zero_R2: assert (!dir_right || arith_mode || (data_out & high_mask) == '0)
      else $error("R2 high fill not zero");
    assert_sign_fill_R3: assert (!(dir_right && arith_mode && data_in[WIDTH-1])
                                 || (data_out & high_mask) == high_mask)
      else $error("R3 sign fill missing");
    assert_full_left_R6: assert (dir_right || shift_amt != SHW'(WIDTH-1)
                                 || data_out == {data_in[0], {(WIDTH-1){1'b0}}})
      else $error("R6 full-width left shift wrong");
  end
endmodule

bind bidir_barrel_shifter bidir_barrel_shifter_chk #(.WIDTH(WIDTH)) chk_i (
  .data_in    (data_in),
  .shift_amt  (shift_amt),
  .dir_right  (dir_right),
  .arith_mode (arith_mode),
  .data_out   (data_out)
);

// File: tb/bidir_barrel_shifter_tb_top.sv
module bidir_barrel_shifter_tb_top;
  localparam int W   = 8;
  localparam int SHW = $clog2(W);

  logic         clk;
  logic         rst_n;
  logic [W-1:0] data_in;
  logic [SHW-1:0] shift_amt;
  logic         dir_right;
  logic         arith_mode;
  logic [W-1:0] data_out;

  int n_checks;
  int n_fails;
  int wd_cnt;
  bit done;

  bidir_barrel_shifter #(.WIDTH(W)) dut_i (
    .data_in    (data_in),
    .shift_amt  (shift_amt),
    .dir_right  (dir_right),
    .arith_mode (arith_mode),
    .data_out   (data_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: in=%b amt=%0d dir=%0b ar=%0b actual=%b expected=%b",
               req, data_in, shift_amt, dir_right, arith_mode, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                         input logic r, input logic ar);
    if (!r)     return d << a;
    else if (ar) return W'($signed(d) >>> a);
    else        return d >> a;
  endfunction

  task automatic apply(input logic [W-1:0] d, input int a, input logic r, input logic ar);
    @(negedge clk);
    data_in    = d;
    shift_amt  = SHW'(a);
    dir_right  = r;
    arith_mode = ar;
    #5;
  endtask

  // Watchdog
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_cnt <= 0;
    else        wd_cnt <= wd_cnt + 1;
  end

  initial begin
    n_checks = 0; n_fails = 0; done = 0;
    rst_n = 1'b0;
    data_in = '0; shift_amt = '0; dir_right = 0; arith_mode = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #5;
    check("R5 idle zero", data_out, '0);

    // Named example from R3
    apply(8'b11101100, 1, 1, 1);
    check("R3 example", data_out, 8'b11110110);

    for (int d = 0; d < (1 << W); d++) begin
      for (int a = 0; a < W; a++) begin
        for (int r = 0; r < 2; r++) begin
          for (int ar = 0; ar < 2; ar++) begin
            logic [W-1:0] dv;
            logic [W-1:0] exp;
            string tag;
            dv = W'(d);
            apply(dv, a, r[0], ar[0]);
            if (a == 0) begin
              exp = dv; tag = "R5";
            end else if (!r[0] && a == W-1) begin
              exp = {dv[0], {(W-1){1'b0}}}; tag = "R6";
            end else if (r[0] && a == W-1) begin
              exp = ar[0] ? {W{dv[W-1]}} : {{(W-1){1'b0}}, dv[W-1]}; tag = "R7";
            end else begin
              exp = model(dv, a, r[0], ar[0]);
              if (!r[0])     tag = ar[0] ? "R4" : "R1";
              else if (ar[0]) tag = "R3";
              else           tag = "R2";
            end
            check(tag, data_out, exp);
            if (!r[0] && ar[0]) begin
              logic [W-1:0] with_ar;
              with_ar = data_out;
              apply(dv, a, 1'b0, 1'b0);
              check("R4 mode ignored", with_ar, data_out);
            end
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    wait (done || wd_cnt >= 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule